// File: doc/BRIEF.md
# PLL Bring-Up Clock Sequencer

This block moves the system clock from the internal oscillator onto the PLL output in a fixed, safe order. Its input is a single start pulse. It first bypasses the PLL and then powers it down. Next it drives the new reference-oscillator select and requests that the system divider be set to one. It then loads the multiplier and divider word in one write, and that write powers the PLL up.

Once the PLL reports lock, the block counts rising edges of the raw PLL clock over a programmed window of reference cycles. It switches the system clock to the PLL only if that count falls inside the programmed bounds. Each early step is followed by a fixed settling wait. A missing lock or a bad frequency leaves the block parked in an error state that records the cause.

The analog PLL, the oscillators and the glitch-free clock mux lie outside the block. They appear only as the control outputs and status inputs listed below.

Top module: `clk_bringup_seq`

## Requirements
- R1: After reset, `pll_clk_en_o`, `pll_pwr_en_o`, `div1_wr_o`, `pll_cfg_wr_o`, `busy_o`, `done_o` and `err_o` are 0, and `osc_sel_o` and `err_code_o` are 0 (internal oscillator, no error).
- R2: A `start_i` sampled while idle sets `busy_o`, clears `pll_clk_en_o` and `done_o` one cycle later, and captures the select, configuration word, window, bounds and timeout inputs.
- R3: `pll_pwr_en_o` falls exactly 60 cycles after `pll_clk_en_o` was cleared by the start.
- R4: `osc_sel_o` takes the captured select exactly 60 cycles after power-down, and it changes only while both `pll_clk_en_o` and `pll_pwr_en_o` are 0.
- R5: Exactly 300 cycles after the select change, `div1_wr_o` pulses for one cycle. In the next cycle `pll_cfg_wr_o` pulses once, `pll_cfg_o` shows the captured word and `pll_pwr_en_o` rises.
- R6: After the load, the block waits in the lock state. The first cycle that samples `pll_lock_i` = 1 starts the frequency measurement.
- R7: If lock is not seen within `lock_tmo_i` cycles of the load, `err_o` rises and `err_code_o` = 2'b01.
- R8: The measurement counts rising edges of `pll_clk_i`, passed through a two-flop synchroniser, over `win_len_i` cycles. It passes when `lo_i` <= count <= `hi_i`.
- R9: On a pass, `pll_clk_en_o` and `done_o` rise and `busy_o` falls, all in the same cycle, right after the last window cycle.
- R10: On a fail, `err_o` = 1 and `err_code_o` = 2'b10, and `pll_clk_en_o` stays 0.
- R11: `start_i` is ignored while `busy_o` or `err_o` is 1: no output changes because of it.
- R12: `clear_i` during an error returns the block to idle with `err_o` = 0 and `err_code_o` = 0. Outside an error it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System/reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| clear_i | input | 1 | Error clear pulse |
| osc_sel_i | input | 2 | Target reference-oscillator select |
| pll_cfg_i | input | 32 | Multiplier/divider configuration word |
| win_len_i | input | 16 | Measurement window in cycles |
| lo_i | input | 16 | Lowest accepted edge count |
| hi_i | input | 16 | Highest accepted edge count |
| lock_tmo_i | input | 16 | Lock wait limit in cycles |
| pll_lock_i | input | 1 | PLL lock status |
| pll_clk_i | input | 1 | Raw PLL clock (asynchronous) |
| pll_clk_en_o | output | 1 | 1 selects the PLL as system clock (0 = bypass) |
| pll_pwr_en_o | output | 1 | PLL power enable |
| osc_sel_o | output | 2 | Reference-oscillator select |
| div1_wr_o | output | 1 | One-cycle request to set the system divider to one |
| pll_cfg_wr_o | output | 1 | One-cycle load strobe for `pll_cfg_o` |
| pll_cfg_o | output | 32 | Configuration word being loaded |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | PLL is the system clock |
| err_o | output | 1 | Sequence halted on an error |
| err_code_o | output | 2 | 01 lock timeout, 10 frequency out of range |

## Verification
Every output is registered, so each result appears one edge after the condition that causes it. A start shows up the next cycle. Power-down follows 60 cycles later, the select change another 60 later, and the divider request 300 cycles after that. The load comes one cycle after the divider request. The switch or error comes one cycle after the last window cycle, or after the cycle in which the lock wait runs out. A behavioural model in the bench advances on the same edge as the design and is compared with it at each falling edge, so every one of these latencies is checked on the exact cycle. The measurement bounds are set at least four counts away from the expected edge count, so synchroniser phase cannot flip the pass/fail verdict.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_BYP, S_PDN, S_SEL, S_DIV1, S_LOCK, S_MEAS, S_ERR
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_LOCK = 2'd1,
        ERR_FREQ = 2'd2
    } seq_err_e;
endpackage

// File: rtl/clkseq_sync_rise.sv
module clkseq_sync_rise #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // rising edge seen after the synchroniser stages
    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/clkseq_freq_cmp.sv
module clkseq_freq_cmp #(
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            edge_i,
    input  logic [CNTW-1:0] win_i,
    input  logic [CNTW-1:0] lo_i,
    input  logic [CNTW-1:0] hi_i,
    output logic            end_o,
    output logic            pass_o
);
    localparam logic [CNTW:0] ONE_X = (CNTW+1)'(1);

    logic [CNTW-1:0] win_d, win_q;
    logic [CNTW-1:0] edg_d, edg_q;
    logic [CNTW-1:0] total;

    always_comb begin
        total  = edg_q + {{(CNTW-1){1'b0}}, edge_i};
        end_o  = run_i && (({1'b0, win_q} + ONE_X) >= {1'b0, win_i});
        pass_o = (total >= lo_i) && (total <= hi_i);
        if (run_i) begin
            win_d = win_q + CNTW'(1);
            edg_d = total;
        end else begin
            win_d = '0;
            edg_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
            edg_q <= '0;
        end else begin
            win_q <= win_d;
            edg_q <= edg_d;
        end
    end
endmodule

// File: rtl/clk_bringup_seq.sv
module clk_bringup_seq
    import clkseq_pkg::*;
#(
    parameter int CNTW        = 16,
    parameter int CFGW        = 32,
    parameter int SELW        = 2,
    parameter int BYP_WAIT    = 60,
    parameter int PDN_WAIT    = 60,
    parameter int SEL_WAIT    = 300,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            clear_i,
    input  logic [SELW-1:0] osc_sel_i,
    input  logic [CFGW-1:0] pll_cfg_i,
    input  logic [CNTW-1:0] win_len_i,
    input  logic [CNTW-1:0] lo_i,
    input  logic [CNTW-1:0] hi_i,
    input  logic [CNTW-1:0] lock_tmo_i,
    input  logic            pll_lock_i,
    input  logic            pll_clk_i,
    output logic            pll_clk_en_o,
    output logic            pll_pwr_en_o,
    output logic [SELW-1:0] osc_sel_o,
    output logic            div1_wr_o,
    output logic            pll_cfg_wr_o,
    output logic [CFGW-1:0] pll_cfg_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            err_o,
    output logic [1:0]      err_code_o
);
    localparam logic [CNTW-1:0] BYP_LAST = CNTW'(BYP_WAIT - 1);
    localparam logic [CNTW-1:0] PDN_LAST = CNTW'(PDN_WAIT - 1);
    localparam logic [CNTW-1:0] SEL_LAST = CNTW'(SEL_WAIT - 1);
    localparam logic [CNTW:0]   ONE_X    = (CNTW+1)'(1);

    typedef struct packed {
        seq_state_e      state;
        logic [CNTW-1:0] cnt;
        logic            clk_en;
        logic            pwr_en;
        logic [SELW-1:0] osc_sel;
        logic            div_wr;
        logic            cfg_wr;
        logic [CFGW-1:0] cfg;
        logic            busy;
        logic            done;
        logic            err;
        seq_err_e        code;
        logic [SELW-1:0] t_sel;
        logic [CFGW-1:0] t_cfg;
        logic [CNTW-1:0] t_win;
        logic [CNTW-1:0] t_lo;
        logic [CNTW-1:0] t_hi;
        logic [CNTW-1:0] t_tmo;
    } seq_regs_t;

    seq_regs_t d, q;
    logic      pll_rise;
    logic      meas_end;
    logic      meas_pass;

    clkseq_sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pll_clk_i),
        .rise_o  (pll_rise)
    );

    clkseq_freq_cmp #(.CNTW(CNTW)) u_freq (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (q.state == S_MEAS),
        .edge_i (pll_rise),
        .win_i  (q.t_win),
        .lo_i   (q.t_lo),
        .hi_i   (q.t_hi),
        .end_o  (meas_end),
        .pass_o (meas_pass)
    );

    always_comb begin
        d        = q;
        d.div_wr = 1'b0;
        d.cfg_wr = 1'b0;
        unique case (q.state)
            S_IDLE: if (start_i) begin
                d.state  = S_BYP;
                d.cnt    = '0;
                d.clk_en = 1'b0;
                d.busy   = 1'b1;
                d.done   = 1'b0;
                d.t_sel  = osc_sel_i;
                d.t_cfg  = pll_cfg_i;
                d.t_win  = win_len_i;
                d.t_lo   = lo_i;
                d.t_hi   = hi_i;
                d.t_tmo  = lock_tmo_i;
            end
            S_BYP: if (q.cnt == BYP_LAST) begin
                d.state  = S_PDN;
                d.cnt    = '0;
                d.pwr_en = 1'b0;
            end else d.cnt = q.cnt + CNTW'(1);
            S_PDN: if (q.cnt == PDN_LAST) begin
                d.state   = S_SEL;
                d.cnt     = '0;
                d.osc_sel = q.t_sel;
            end else d.cnt = q.cnt + CNTW'(1);
            S_SEL: if (q.cnt == SEL_LAST) begin
                d.state  = S_DIV1;
                d.cnt    = '0;
                d.div_wr = 1'b1;
            end else d.cnt = q.cnt + CNTW'(1);
            S_DIV1: begin
                d.state  = S_LOCK;
                d.cnt    = '0;
                d.cfg_wr = 1'b1;
                d.cfg    = q.t_cfg;
                d.pwr_en = 1'b1;
            end
            S_LOCK: if (pll_lock_i) begin
                d.state = S_MEAS;
                d.cnt   = '0;
            end else if (({1'b0, q.cnt} + ONE_X) >= {1'b0, q.t_tmo}) begin
                d.state = S_ERR;
                d.busy  = 1'b0;
                d.err   = 1'b1;
                d.code  = ERR_LOCK;
            end else d.cnt = q.cnt + CNTW'(1);
            S_MEAS: if (meas_end) begin
                d.busy = 1'b0;
                if (meas_pass) begin
                    d.state  = S_IDLE;
                    d.clk_en = 1'b1;
                    d.done   = 1'b1;
                end else begin
                    d.state = S_ERR;
                    d.err   = 1'b1;
                    d.code  = ERR_FREQ;
                end
            end
            S_ERR: if (clear_i) begin
                d.state = S_IDLE;
                d.err   = 1'b0;
                d.code  = ERR_NONE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
            q.code  <= ERR_NONE;
        end else begin
            q <= d;
        end
    end

    assign pll_clk_en_o = q.clk_en;
    assign pll_pwr_en_o = q.pwr_en;
    assign osc_sel_o    = q.osc_sel;
    assign div1_wr_o    = q.div_wr;
    assign pll_cfg_wr_o = q.cfg_wr;
    assign pll_cfg_o    = q.cfg;
    assign busy_o       = q.busy;
    assign done_o       = q.done;
    assign err_o        = q.err;
    assign err_code_o   = q.code;
endmodule

// File: rtl/clk_bringup_seq_chk.sv
module clk_bringup_seq_chk #(
    parameter int SELW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clear_i,
    input logic            pll_clk_en_o,
    input logic            pll_pwr_en_o,
    input logic [SELW-1:0] osc_sel_o,
    input logic            div1_wr_o,
    input logic            pll_cfg_wr_o,
    input logic            busy_o,
    input logic            done_o,
    input logic            err_o,
    input logic [1:0]      err_code_o
);
    assert_busy_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!pll_clk_en_o && !done_o));

    assert_pdn_bypassed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_pwr_en_o) |-> !pll_clk_en_o);

    assert_sel_safe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(osc_sel_o) |-> (!pll_clk_en_o && !pll_pwr_en_o));

    assert_div_then_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div1_wr_o |=> pll_cfg_wr_o);

    assert_load_powers_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pll_cfg_wr_o |-> (pll_pwr_en_o && !pll_clk_en_o));

    assert_switch_on_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_clk_en_o) |-> (done_o && !busy_o && !err_o));

    assert_err_coded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (err_code_o != 2'd0 && !busy_o && !pll_clk_en_o));

    assert_clear_exits_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && clear_i) |=> !err_o);
endmodule

bind clk_bringup_seq clk_bringup_seq_chk #(.SELW(SELW)) u_chk (.*);

// File: tb/clk_bringup_seq_bench.sv
module clk_bringup_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PLL_HALF   = 2;   // pll_clk_i toggles every 2 cycles: one rise per 4

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, clear_i = 1'b0;
    logic [1:0]  osc_sel_i = '0;
    logic [31:0] pll_cfg_i = '0;
    logic [15:0] win_len_i = '0, lo_i = '0, hi_i = '0, lock_tmo_i = '0;
    logic        pll_lock_i = 1'b0, pll_clk_i = 1'b0;
    logic        pll_clk_en_o, pll_pwr_en_o, div1_wr_o, pll_cfg_wr_o;
    logic        busy_o, done_o, err_o;
    logic [1:0]  osc_sel_o, err_code_o;
    logic [31:0] pll_cfg_o;

    int tests = 0, fails = 0, cyc = 0, pll_div = 0;

    // reference model state
    int m_ph = 0, m_n = 0;
    logic m_clk_en = 0, m_pwr = 0, m_div = 0, m_cfgwr = 0, m_busy = 0, m_done = 0, m_err = 0, m_pass = 0;
    logic [1:0]  m_sel = 0, m_code = 0, m_tsel = 0;
    logic [31:0] m_cfg = 0, m_tcfg = 0;
    int m_win = 0, m_tmo = 0;

    clk_bringup_seq u_clk_bringup_seq (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // behavioural reference, one step per rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_n = 0; m_clk_en = 0; m_pwr = 0; m_div = 0; m_cfgwr = 0;
            m_busy = 0; m_done = 0; m_err = 0; m_sel = 0; m_code = 0; m_cfg = 0;
        end else begin
            m_div = 0; m_cfgwr = 0;
            case (m_ph)
                0: if (start_i) begin
                    m_tsel = osc_sel_i; m_tcfg = pll_cfg_i; m_win = win_len_i; m_tmo = lock_tmo_i;
                    // expected edge count is win/4, bounds chosen well away from it
                    m_pass = (int'(lo_i) <= m_win / (2*PLL_HALF)) && (m_win / (2*PLL_HALF) <= int'(hi_i));
                    m_ph = 1; m_n = 0; m_clk_en = 0; m_busy = 1; m_done = 0;
                end
                1: begin m_n++; if (m_n == 60) begin m_ph = 2; m_n = 0; m_pwr = 0; end end
                2: begin m_n++; if (m_n == 60) begin m_ph = 3; m_n = 0; m_sel = m_tsel; end end
                3: begin m_n++; if (m_n == 300) begin m_ph = 4; m_n = 0; m_div = 1; end end
                4: begin m_ph = 5; m_n = 0; m_cfgwr = 1; m_cfg = m_tcfg; m_pwr = 1; end
                5: if (pll_lock_i) begin m_ph = 6; m_n = 0; end
                   else begin
                       m_n++;
                       if (m_n >= m_tmo) begin m_ph = 7; m_busy = 0; m_err = 1; m_code = 2'd1; end
                   end
                6: begin
                    m_n++;
                    if (m_n >= m_win) begin
                        m_busy = 0;
                        if (m_pass) begin m_ph = 0; m_clk_en = 1; m_done = 1; end
                        else begin m_ph = 7; m_err = 1; m_code = 2'd2; end
                    end
                end
                default: if (clear_i) begin m_ph = 0; m_err = 0; m_code = 0; end
            endcase
        end
    end

    // raw PLL clock stimulus and per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        pll_div++;
        if (pll_div == PLL_HALF) begin pll_div = 0; pll_clk_i = ~pll_clk_i; end
        if (rst_n) begin
            chk("R9 pll_clk_en_o", {31'd0, pll_clk_en_o}, {31'd0, m_clk_en});
            chk("R3 pll_pwr_en_o", {31'd0, pll_pwr_en_o}, {31'd0, m_pwr});
            chk("R4 osc_sel_o", {30'd0, osc_sel_o}, {30'd0, m_sel});
            chk("R5 div1_wr_o", {31'd0, div1_wr_o}, {31'd0, m_div});
            chk("R5 pll_cfg_wr_o", {31'd0, pll_cfg_wr_o}, {31'd0, m_cfgwr});
            chk("R5 pll_cfg_o", pll_cfg_o, m_cfg);
            chk("R2 busy_o", {31'd0, busy_o}, {31'd0, m_busy});
            chk("R9 done_o", {31'd0, done_o}, {31'd0, m_done});
            chk("R10 err_o", {31'd0, err_o}, {31'd0, m_err});
            chk("R7 err_code_o", {30'd0, err_code_o}, {30'd0, m_code});
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) if (cyc == 150000) begin
        tests++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

    task automatic pulse_start(logic [1:0] sel);
        osc_sel_i = sel; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // one sequence; lock_dly < 0 means lock never arrives
    task automatic run(logic [1:0] sel, logic [31:0] cfg, int win, int lo, int hi, int tmo,
                       int lock_dly, bit poke_busy);
        pll_cfg_i = cfg; win_len_i = 16'(win); lo_i = 16'(lo); hi_i = 16'(hi); lock_tmo_i = 16'(tmo);
        pll_lock_i = 1'b0;
        pulse_start(sel);
        // scramble inputs after capture
        pll_cfg_i = ~cfg; win_len_i = 16'd3; lo_i = 16'd0; hi_i = 16'd0; osc_sel_i = ~sel;
        chk("R2 busy after start", {31'd0, busy_o}, 32'd1);
        if (poke_busy) begin
            repeat (10) @(negedge clk);
            pulse_start(~sel);   // R11: must be ignored
        end
        while (!pll_cfg_wr_o) @(negedge clk);
        chk("R5 config word loaded", pll_cfg_o, cfg);
        if (lock_dly >= 0) begin
            repeat (lock_dly) @(negedge clk);
            pll_lock_i = 1'b1;
        end
        while (busy_o) @(negedge clk);
        pll_lock_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 clk_en reset", {31'd0, pll_clk_en_o}, 32'd0);
        chk("R1 pwr_en reset", {31'd0, pll_pwr_en_o}, 32'd0);
        chk("R1 osc_sel reset", {30'd0, osc_sel_o}, 32'd0);
        chk("R1 status reset", {29'd0, busy_o, done_o, err_o}, 32'd0);
        chk("R1 err_code reset", {30'd0, err_code_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // passing sequence, extra start while busy (R6, R8, R11)
        run(2'd2, 32'hA5C3_1E07, 64, 12, 20, 200, 20, 1'b1);
        chk("R8 pass done", {31'd0, done_o}, 32'd1);
        chk("R11 start while busy ignored", {30'd0, osc_sel_o}, 32'd2);
        chk("R9 switched", {31'd0, pll_clk_en_o}, 32'd1);

        // R12: clear outside error has no effect
        clear_i = 1'b1; @(negedge clk); clear_i = 1'b0; @(negedge clk);
        chk("R12 clear idle no effect", {30'd0, done_o, err_o}, 32'd2);

        // frequency out of range (R10)
        run(2'd1, 32'h0000_0F0F, 64, 30, 40, 200, 5, 1'b0);
        chk("R10 freq error", {30'd0, err_code_o}, 32'd2);
        chk("R10 stays bypassed", {31'd0, pll_clk_en_o}, 32'd0);

        // R11: start while in error ignored
        pulse_start(2'd3);
        @(negedge clk);
        chk("R11 start in error ignored", {30'd0, busy_o, err_o}, 32'd1);
        chk("R11 select unchanged", {30'd0, osc_sel_o}, 32'd1);

        // R12: clear in error
        clear_i = 1'b1; @(negedge clk); clear_i = 1'b0;
        chk("R12 clear error", {29'd0, err_o, err_code_o}, 32'd0);

        // lock timeout (R7)
        run(2'd3, 32'h1234_5678, 64, 12, 20, 50, -1, 1'b0);
        chk("R7 lock timeout code", {30'd0, err_code_o}, 32'd1);
        clear_i = 1'b1; @(negedge clk); clear_i = 1'b0;

        // another pass with a different window, lock at the first lock cycle (R6, R8)
        run(2'd0, 32'hDEAD_0001, 40, 6, 14, 10, 0, 1'b0);
        chk("R6 R8 second pass", {30'd0, done_o, pll_clk_en_o}, 32'd3);

        repeat (5) @(negedge clk);
        summary();
    end
endmodule